// File: doc/BRIEF.md
# Display Compositor Interrupt Status Unit

This block gathers event and error conditions from the display channels of a pixel compositor and from the compositor's bus and DMA paths. Each condition sets a sticky flag. The flags are merged into per-display, DMA, bus-slave and profiler summary flags, and these drive one registered interrupt line. Event sources are single-cycle pulses or levels from the compositor datapath: line start, frame start, a pending-pixels indication, FIFO read and empty, FIFO low-water, line completion with its line number, and the display mode.

Software reaches the block through a small register port with four selects. Select 0 is the enable word. Select 1 is the status word. Select 2 is the line-match target. Select 3 reads zero. Reads are combinational. A write of a 1 to status bit 0 clears every flag at once. Within each display's summary the enables are grouped unevenly. A short frame always counts. Short line and underflow share one enable. End of frame and end of the target line each have their own enable.

Top module: `cmp_irq_status`

## Requirements
- R1: Each display d keeps six sticky flags at status bits 12+6d+k, where k=0 is end of frame, 1 is target line done, 2 is short frame, 3 is short line, 4 is underflow and 5 is FIFO low. A flag, once set, holds until a clear-all. A FIFO-low pulse sets k=5.
- R2: A line-start pulse that arrives while the display's pending input is high sets the short-line flag. Without pending it sets nothing.
- R3: A frame-start pulse that arrives while pending is high sets the short-frame flag.
- R4: A FIFO read pulse while the FIFO-empty input is high sets the underflow flag.
- R5: The end-of-frame flag sets only when the 2-bit mode input (0 off, 1 init, 2 run, 3 eof) goes from 2 in one cycle to 3 in the next.
- R6: A line-done pulse whose line number equals the target register (select 2, bits LINE_W-1:0) sets the target-line flag. Any other number does not.
- R7: Status bit 1+d is the display's summary. It is (end of frame AND enable bit 8+3d) OR (target line AND enable bit 9+3d) OR short frame OR ((short line OR underflow) AND enable bit 10+3d). FIFO low does not contribute.
- R8: Status bit 7 is the sticky DMA ID error flag. Bits 9:8 hold the last bus response captured on a response-valid cycle (0 OKAY, 1 EXOKAY, 2 SLVERR, 3 DECERR). Bit 4 is the DMA summary, set when bit 7 is set or the captured response is not 0.
- R9: Bit 5 holds the sticky slave write decode error, bit 6 the sticky slave read decode error, and bit 0 the sticky profiler flag.
- R10: A status write with data bit 0 set clears all flags and resets the captured response to 0. With bit 0 clear, a status write changes nothing. An event in the same cycle as a clear-all still sets its flag.
- R11: One cycle after the flags change, irq equals the OR of: profiler flag AND enable bit 0, display d summary AND enable bit 1+d, DMA summary AND enable bit 4, slave write flag AND enable bit 5, and slave read flag AND enable bit 6.
- R12: After reset, status, enables, target and irq read 0. The enable word reads back all 32 bits as written. The target reads back zero-extended. Select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 2 | Write select (0 enable, 1 status, 2 target) |
| reg_wr_data | input | 32 | Write data |
| reg_rd_sel | input | 2 | Read select |
| reg_rd_data | output | 32 | Read data, combinational |
| hstart_pulse | input | NUM_DISP | Line-start pulse per display |
| vstart_pulse | input | NUM_DISP | Frame-start pulse per display |
| line_pending | input | NUM_DISP | Pixels of the current output line still pending |
| fifo_rd_pulse | input | NUM_DISP | Downstream read of the display FIFO |
| fifo_empty | input | NUM_DISP | Display FIFO empty |
| fifo_low_pulse | input | NUM_DISP | FIFO low-water event |
| line_done_pulse | input | NUM_DISP | A line finished compositing |
| line_done_num | input | NUM_DISP*LINE_W | Number of the finished line, per display |
| disp_mode | input | 2*NUM_DISP | Display mode per display |
| prof_pulse | input | 1 | Profiler event |
| dma_id_err_pulse | input | 1 | DMA ID error |
| resp_valid | input | 1 | Bus response capture strobe |
| resp_code | input | 2 | Bus response code |
| slv_rd_err_pulse | input | 1 | Slave read decode error |
| slv_wr_err_pulse | input | 1 | Slave write decode error |
| irq | output | 1 | Registered interrupt |

## Verification
A lost or stuck flag shows in the status word at the first read after the edge that should have set or cleared it. A summary that gates its sources wrongly is visible in bits 1 to 4 in that same cycle. A fault in the interrupt merge or its register shows on irq exactly one cycle later. The bench keeps a cycle model of every flag, so any divergence is caught on the edge where it first occurs. It does not surface frames later.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;
  localparam int REG_W          = 32;
  localparam int FLAG_N         = 6;
  localparam int ST_DISP_BASE   = 12;
  localparam int ST_DISP_STRIDE = 6;
  localparam int EN_DISP_BASE   = 8;
  localparam int EN_DISP_STRIDE = 3;

  localparam logic [1:0] SEL_EN   = 2'd0;
  localparam logic [1:0] SEL_ST   = 2'd1;
  localparam logic [1:0] SEL_LINE = 2'd2;

  // flag index inside one display group
  localparam int FL_EOF   = 0;
  localparam int FL_EOLN  = 1;
  localparam int FL_SFRM  = 2;
  localparam int FL_SLINE = 3;
  localparam int FL_UFLOW = 4;
  localparam int FL_FLOW  = 5;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_INIT = 2'd1,
    MODE_RUN  = 2'd2,
    MODE_EOF  = 2'd3
  } disp_mode_e;

  // en: {shared short-line/underflow, line-match, end-of-frame}
  function automatic logic disp_summary(input logic [FLAG_N-1:0] f, input logic [2:0] en);
    return (f[FL_EOF] & en[0]) | (f[FL_EOLN] & en[1]) | f[FL_SFRM] |
           ((f[FL_SLINE] | f[FL_UFLOW]) & en[2]);
  endfunction
endpackage

// File: rtl/cmp_disp_flags.sv
module cmp_disp_flags
  import cmp_irq_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_all,
  input  logic              hstart,
  input  logic              vstart,
  input  logic              pending,
  input  logic              fifo_rd,
  input  logic              fifo_empty,
  input  logic              fifo_low,
  input  logic              line_done,
  input  logic [LINE_W-1:0] line_num,
  input  logic [LINE_W-1:0] line_target,
  input  logic [1:0]        mode,
  output logic [FLAG_N-1:0] flags
);
  logic [1:0]        mode_q;
  logic              ev_eof, ev_eoln, ev_sfrm, ev_sline, ev_uflow;
  logic [FLAG_N-1:0] set_vec;

  assign ev_eof   = (mode_q == MODE_RUN) && (mode == MODE_EOF);
  assign ev_eoln  = line_done && (line_num == line_target);
  assign ev_sfrm  = vstart && pending;
  assign ev_sline = hstart && pending;
  assign ev_uflow = fifo_rd && fifo_empty;

  always_comb begin
    set_vec           = '0;
    set_vec[FL_EOF]   = ev_eof;
    set_vec[FL_EOLN]  = ev_eoln;
    set_vec[FL_SFRM]  = ev_sfrm;
    set_vec[FL_SLINE] = ev_sline;
    set_vec[FL_UFLOW] = ev_uflow;
    set_vec[FL_FLOW]  = fifo_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      flags  <= '0;
    end else begin
      mode_q <= mode;
      flags  <= (flags & {FLAG_N{~clr_all}}) | set_vec;
    end
  end

  a_r1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FL_FLOW] && !clr_all) |=> flags[FL_FLOW]);
  a_r2_short_line: assert property (@(posedge clk) disable iff (!rst_n)
    (hstart && pending) |=> flags[FL_SLINE]);
  a_r3_short_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (vstart && pending) |=> flags[FL_SFRM]);
  a_r4_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd && fifo_empty) |=> flags[FL_UFLOW]);
  a_r5_eof_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags[FL_EOF] && !(mode_q == MODE_RUN && mode == MODE_EOF)) |=> !flags[FL_EOF]);
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && fifo_low) |=> flags[FL_FLOW]);
endmodule

// File: rtl/cmp_bus_flags.sv
module cmp_bus_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_all,
  input  logic       prof_pulse,
  input  logic       dma_id_err,
  input  logic       resp_valid,
  input  logic [1:0] resp_code,
  input  logic       slv_rd_err,
  input  logic       slv_wr_err,
  output logic       prof_f,
  output logic       dma_id_f,
  output logic       slv_rd_f,
  output logic       slv_wr_f,
  output logic [1:0] resp_q,
  output logic       dma_sum
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prof_f   <= 1'b0;
      dma_id_f <= 1'b0;
      slv_rd_f <= 1'b0;
      slv_wr_f <= 1'b0;
      resp_q   <= 2'd0;
    end else begin
      prof_f   <= (prof_f   & ~clr_all) | prof_pulse;
      dma_id_f <= (dma_id_f & ~clr_all) | dma_id_err;
      slv_rd_f <= (slv_rd_f & ~clr_all) | slv_rd_err;
      slv_wr_f <= (slv_wr_f & ~clr_all) | slv_wr_err;
      if (resp_valid)   resp_q <= resp_code;
      else if (clr_all) resp_q <= 2'd0;
    end
  end

  assign dma_sum = dma_id_f | (resp_q != 2'd0);

  a_r8_bad_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_code != 2'd0) |=> dma_sum);
  a_r9_slave_wr: assert property (@(posedge clk) disable iff (!rst_n)
    slv_wr_err |=> slv_wr_f);
  a_r9_slave_rd: assert property (@(posedge clk) disable iff (!rst_n)
    slv_rd_err |=> slv_rd_f);
endmodule

// File: rtl/cmp_irq_status.sv
module cmp_irq_status
  import cmp_irq_pkg::*;
#(
  parameter int NUM_DISP = 3,
  parameter int LINE_W   = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr_en,
  input  logic [1:0]                 reg_wr_sel,
  input  logic [31:0]                reg_wr_data,
  input  logic [1:0]                 reg_rd_sel,
  output logic [31:0]                reg_rd_data,
  input  logic [NUM_DISP-1:0]        hstart_pulse,
  input  logic [NUM_DISP-1:0]        vstart_pulse,
  input  logic [NUM_DISP-1:0]        line_pending,
  input  logic [NUM_DISP-1:0]        fifo_rd_pulse,
  input  logic [NUM_DISP-1:0]        fifo_empty,
  input  logic [NUM_DISP-1:0]        fifo_low_pulse,
  input  logic [NUM_DISP-1:0]        line_done_pulse,
  input  logic [NUM_DISP*LINE_W-1:0] line_done_num,
  input  logic [2*NUM_DISP-1:0]      disp_mode,
  input  logic                       prof_pulse,
  input  logic                       dma_id_err_pulse,
  input  logic                       resp_valid,
  input  logic [1:0]                 resp_code,
  input  logic                       slv_rd_err_pulse,
  input  logic                       slv_wr_err_pulse,
  output logic                       irq
);
  // layout holds three display groups; NUM_DISP must stay at or below 3
  localparam int NUM_SRC = NUM_DISP + 4;

  logic [REG_W-1:0]  en_q;
  logic [LINE_W-1:0] line_q;
  logic              clr_all;
  logic [FLAG_N-1:0] dflags [NUM_DISP];
  logic [NUM_DISP-1:0] disp_sum;
  logic              prof_f, dma_id_f, slv_rd_f, slv_wr_f, dma_sum;
  logic [1:0]        resp_q;
  logic [NUM_SRC-1:0] src_gated;
  logic              src_any;
  logic              irq_q;
  logic [REG_W-1:0]  status_w;
  logic              evt_any;

  assign clr_all = reg_wr_en && (reg_wr_sel == SEL_ST) && reg_wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      line_q <= '0;
    end else if (reg_wr_en) begin
      if (reg_wr_sel == SEL_EN)   en_q   <= reg_wr_data;
      if (reg_wr_sel == SEL_LINE) line_q <= reg_wr_data[LINE_W-1:0];
    end
  end

  for (genvar d = 0; d < NUM_DISP; d++) begin : g_disp
    cmp_disp_flags #(.LINE_W(LINE_W)) u_disp (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_all    (clr_all),
      .hstart     (hstart_pulse[d]),
      .vstart     (vstart_pulse[d]),
      .pending    (line_pending[d]),
      .fifo_rd    (fifo_rd_pulse[d]),
      .fifo_empty (fifo_empty[d]),
      .fifo_low   (fifo_low_pulse[d]),
      .line_done  (line_done_pulse[d]),
      .line_num   (line_done_num[d*LINE_W +: LINE_W]),
      .line_target(line_q),
      .mode       (disp_mode[2*d +: 2]),
      .flags      (dflags[d])
    );
    assign disp_sum[d] = disp_summary(dflags[d],
                           en_q[EN_DISP_BASE + EN_DISP_STRIDE*d +: 3]);
    assign src_gated[1+d] = disp_sum[d] & en_q[1+d];
  end

  cmp_bus_flags u_bus (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_all    (clr_all),
    .prof_pulse (prof_pulse),
    .dma_id_err (dma_id_err_pulse),
    .resp_valid (resp_valid),
    .resp_code  (resp_code),
    .slv_rd_err (slv_rd_err_pulse),
    .slv_wr_err (slv_wr_err_pulse),
    .prof_f     (prof_f),
    .dma_id_f   (dma_id_f),
    .slv_rd_f   (slv_rd_f),
    .slv_wr_f   (slv_wr_f),
    .resp_q     (resp_q),
    .dma_sum    (dma_sum)
  );

  assign src_gated[0]          = prof_f   & en_q[0];
  assign src_gated[NUM_DISP+1] = dma_sum  & en_q[4];
  assign src_gated[NUM_DISP+2] = slv_wr_f & en_q[5];
  assign src_gated[NUM_DISP+3] = slv_rd_f & en_q[6];
  assign src_any = |src_gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= src_any;
  end
  assign irq = irq_q;

  always_comb begin
    status_w      = '0;
    status_w[0]   = prof_f;
    for (int d = 0; d < NUM_DISP; d++) begin
      status_w[1+d] = disp_sum[d];
      status_w[ST_DISP_BASE + ST_DISP_STRIDE*d +: FLAG_N] = dflags[d];
    end
    status_w[4]   = dma_sum;
    status_w[5]   = slv_wr_f;
    status_w[6]   = slv_rd_f;
    status_w[7]   = dma_id_f;
    status_w[9:8] = resp_q;
  end

  always_comb begin
    case (reg_rd_sel)
      SEL_EN:   reg_rd_data = en_q;
      SEL_ST:   reg_rd_data = status_w;
      SEL_LINE: reg_rd_data = {{(REG_W-LINE_W){1'b0}}, line_q};
      default:  reg_rd_data = '0;
    endcase
  end

  // any input that could set a flag this cycle
  assign evt_any = (|hstart_pulse) | (|vstart_pulse) | (|fifo_rd_pulse) |
                   (|fifo_low_pulse) | (|line_done_pulse) | prof_pulse |
                   dma_id_err_pulse | resp_valid | slv_rd_err_pulse |
                   slv_wr_err_pulse;

  a_r10_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && !evt_any && !(|disp_mode)) |=> (status_w == '0));
  a_r11_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    src_any |=> irq);
  a_r11_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !src_any |=> !irq);
endmodule

// File: tb/sim_cmp_irq_status.sv
module sim_cmp_irq_status;
  localparam int ND = 3;
  localparam int LW = 12;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic wr_en; logic [1:0] wr_sel; logic [31:0] wr_data;
  logic [1:0] rd_sel; logic [31:0] rd_data;
  logic [ND-1:0] hs, vs, pend, frd, femp, flow, ld;
  logic [ND*LW-1:0] ldn;
  logic [2*ND-1:0] mode;
  logic prof, dmae, rv, srd, swr; logic [1:0] rc;
  logic irq;

  cmp_irq_status #(.NUM_DISP(ND), .LINE_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_sel(wr_sel),
    .reg_wr_data(wr_data), .reg_rd_sel(rd_sel), .reg_rd_data(rd_data),
    .hstart_pulse(hs), .vstart_pulse(vs), .line_pending(pend),
    .fifo_rd_pulse(frd), .fifo_empty(femp), .fifo_low_pulse(flow),
    .line_done_pulse(ld), .line_done_num(ldn), .disp_mode(mode),
    .prof_pulse(prof), .dma_id_err_pulse(dmae), .resp_valid(rv),
    .resp_code(rc), .slv_rd_err_pulse(srd), .slv_wr_err_pulse(swr), .irq(irq));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  logic [5:0]  m_fl [ND];
  logic [1:0]  m_mode [ND];
  logic        m_prof, m_dma, m_swr, m_srd, m_irq;
  logic [1:0]  m_resp;
  logic [31:0] m_en;
  logic [LW-1:0] m_line;

  function automatic logic m_dsum(input int d);
    logic [5:0] msk;
    msk = {1'b0, m_en[10+3*d], m_en[10+3*d], 1'b1, m_en[9+3*d], m_en[8+3*d]};
    return |(m_fl[d] & msk);
  endfunction

  function automatic logic [31:0] exp_status();
    logic [31:0] s;
    s = 32'd0;
    s[0] = m_prof;
    for (int d = 0; d < ND; d++) begin
      s[1+d] = m_dsum(d);
      s[12+6*d +: 6] = m_fl[d];
    end
    s[4] = m_dma | (m_resp != 2'd0);
    s[5] = m_swr; s[6] = m_srd; s[7] = m_dma; s[9:8] = m_resp;
    return s;
  endfunction

  function automatic logic exp_src();
    logic r;
    r = (m_prof & m_en[0]) | ((m_dma | (m_resp != 2'd0)) & m_en[4]) |
        (m_swr & m_en[5]) | (m_srd & m_en[6]);
    for (int d = 0; d < ND; d++) r = r | (m_dsum(d) & m_en[1+d]);
    return r;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_sel = 0; wr_data = 0;
    hs = 0; vs = 0; pend = 0; frd = 0; femp = 0; flow = 0; ld = 0; ldn = 0;
    prof = 0; dmae = 0; rv = 0; rc = 0; srd = 0; swr = 0;
  endtask

  task automatic model_reset();
    for (int d = 0; d < ND; d++) begin m_fl[d] = 0; m_mode[d] = 0; end
    m_prof = 0; m_dma = 0; m_swr = 0; m_srd = 0; m_irq = 0; m_resp = 0;
    m_en = 0; m_line = 0;
  endtask

  // apply current inputs for one edge, update model, check status and irq
  task automatic step();
    logic clr, nirq;
    logic [5:0] setv;
    clr  = wr_en && (wr_sel == 2'd1) && wr_data[0];
    nirq = exp_src();
    for (int d = 0; d < ND; d++) begin
      setv = 6'd0;
      setv[0] = (m_mode[d] == 2'd2) && (mode[2*d +: 2] == 2'd3);
      setv[1] = ld[d] && (ldn[d*LW +: LW] == m_line);
      setv[2] = vs[d] && pend[d];
      setv[3] = hs[d] && pend[d];
      setv[4] = frd[d] && femp[d];
      setv[5] = flow[d];
      m_fl[d]   = (clr ? 6'd0 : m_fl[d]) | setv;
      m_mode[d] = mode[2*d +: 2];
    end
    m_prof = (m_prof & ~clr) | prof;
    m_dma  = (m_dma  & ~clr) | dmae;
    m_swr  = (m_swr  & ~clr) | swr;
    m_srd  = (m_srd  & ~clr) | srd;
    if (rv) m_resp = rc; else if (clr) m_resp = 2'd0;
    if (wr_en && wr_sel == 2'd0) m_en = wr_data;
    if (wr_en && wr_sel == 2'd2) m_line = wr_data[LW-1:0];
    @(posedge clk); #1;
    m_irq = nirq;
    rd_sel = 2'd1; #0;
    chk(rd_data, exp_status(), "R1/R2/R3/R4/R5/R6/R7/R8/R9/R10 status");
    chk({31'd0, irq}, {31'd0, m_irq}, "R11 irq");
    idle();
  endtask

  task automatic rd_check(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    rd_sel = sel; #1;
    chk(rd_data, exp, tag);
    rd_sel = 2'd1; #0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    wr_en = 1; wr_sel = sel; wr_data = data;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd20240611);
    idle(); mode = 0; rd_sel = 2'd1; rst_n = 0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R12 reset state
    rd_check(2'd1, 32'd0, "R12 status after reset");
    rd_check(2'd0, 32'd0, "R12 enable after reset");
    rd_check(2'd2, 32'd0, "R12 target after reset");
    chk({31'd0, irq}, 32'd0, "R12 irq after reset");

    // R12 register readback
    wr(2'd0, 32'hA5A5_0000);
    rd_check(2'd0, 32'hA5A5_0000, "R12 enable readback");
    wr(2'd2, 32'hFFFF_F005);
    rd_check(2'd2, 32'h0000_0005, "R12 target zero-extended");
    rd_check(2'd3, 32'd0, "R12 select 3 reads zero");
    wr(2'd0, 32'd0);

    // R2: line start without pending does nothing; with pending sets bit 15
    hs[0] = 1; step();
    chk({31'd0, rd_data[15]}, 32'd0, "R2 no pending");
    hs[0] = 1; pend[0] = 1; step();
    chk({31'd0, rd_data[15]}, 32'd1, "R2 short line");
    // R3: frame start with pending on display 1 -> bit 20, summary bit 2
    vs[1] = 1; pend[1] = 1; step();
    chk({30'd0, rd_data[20], rd_data[2]}, 32'd3, "R3 short frame and summary");
    // R4: underflow display 2 -> bit 28
    frd[2] = 1; femp[2] = 1; step();
    chk({31'd0, rd_data[28]}, 32'd1, "R4 underflow");
    // R7: short line/underflow need shared enable; FIFO low never counts
    flow[0] = 1; step();
    chk({31'd0, rd_data[17]}, 32'd1, "R1 fifo low flag");
    chk({31'd0, rd_data[1]}, 32'd0, "R7 display 0 summary gated");
    wr(2'd0, 32'h0000_0400);
    chk({31'd0, rd_data[1]}, 32'd1, "R7 shared enable opens summary");
    // R10: status write without bit 0 changes nothing
    wr(2'd1, 32'hFFFF_FFFE);
    chk({31'd0, rd_data[15]}, 32'd1, "R10 write without clear bit");
    // R10: clear-all with concurrent frame start on display 2
    wr_en = 1; wr_sel = 2'd1; wr_data = 32'd1; vs[2] = 1; pend[2] = 1; step();
    chk(rd_data, 32'h0400_0008, "R10 set wins over clear");
    wr(2'd1, 32'd1);
    chk(rd_data, 32'd0, "R10 clear-all");

    // R5: 1 -> 3 gives nothing, 2 -> 3 sets end of frame on display 1 (bit 18)
    mode = 6'b00_01_00; step();
    mode = 6'b00_11_00; step();
    chk({31'd0, rd_data[18]}, 32'd0, "R5 init to eof ignored");
    mode = 6'b00_10_00; step();
    mode = 6'b00_11_00; step();
    chk({31'd0, rd_data[18]}, 32'd1, "R5 run to eof");
    mode = 0; step();
    // R6: target line 5 matches on display 0 only when number equals
    ld[0] = 1; ldn[LW-1:0] = 12'd4; step();
    chk({31'd0, rd_data[13]}, 32'd0, "R6 other line ignored");
    ld[0] = 1; ldn[LW-1:0] = 12'd5; step();
    chk({31'd0, rd_data[13]}, 32'd1, "R6 target line");
    // R8 / R9
    rv = 1; rc = 2'd2; step();
    chk({22'd0, rd_data[9:8], 3'd0, rd_data[4], 4'd0}, {22'd0, 2'd2, 3'd0, 1'b1, 4'd0}, "R8 slave error response");
    rv = 1; rc = 2'd0; step();
    chk({31'd0, rd_data[4]}, 32'd0, "R8 okay response clears summary");
    swr = 1; prof = 1; step();
    chk({25'd0, rd_data[6:5], 4'd0, rd_data[0]}, {25'd0, 2'b01, 4'd0, 1'b1}, "R9 slave write and profiler");
    // R11: enable profiler -> irq after one more edge
    wr(2'd0, 32'h0000_0001);
    chk({31'd0, irq}, 32'd0, "R11 irq not yet");
    step();
    chk({31'd0, irq}, 32'd1, "R11 irq registered");
    wr(2'd1, 32'd1);
    step();
    chk({31'd0, irq}, 32'd0, "R11 irq drops after clear");

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      for (int d = 0; d < ND; d++) begin
        hs[d]   = ($urandom % 8) == 0;
        vs[d]   = ($urandom % 16) == 0;
        pend[d] = $urandom % 2;
        frd[d]  = ($urandom % 6) == 0;
        femp[d] = ($urandom % 3) == 0;
        flow[d] = ($urandom % 20) == 0;
        ld[d]   = ($urandom % 5) == 0;
        ldn[d*LW +: LW] = LW'($urandom % 8);
        if (($urandom % 4) == 0) mode[2*d +: 2] = 2'($urandom);
      end
      prof = ($urandom % 40) == 0;
      dmae = ($urandom % 60) == 0;
      rv   = ($urandom % 10) == 0; rc = 2'($urandom);
      srd  = ($urandom % 50) == 0;
      swr  = ($urandom % 50) == 0;
      case ($urandom % 40)
        0: begin wr_en = 1; wr_sel = 2'd1; wr_data = 32'd1; end
        1: begin wr_en = 1; wr_sel = 2'd0; wr_data = $urandom; end
        2: begin wr_en = 1; wr_sel = 2'd2; wr_data = $urandom % 8; end
        3: begin wr_en = 1; wr_sel = 2'd1; wr_data = $urandom & 32'hFFFF_FFFE; end
        default: ;
      endcase
      step();
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule